// File: doc/BRIEF.md
# Shared Pulled-Up Control Line Resolver

This block models one shared, active-low control line that several agents may drive in turn, in a fabric where real tristate wiring is not available. Each agent presents a data value and an output enable. The block merges them into one resolved level that every agent samples. When no agent is enabled, the line rests at its pulled-up level of 1.

Ownership of such a line has a handoff discipline. Only one agent may drive the line at a time. An owner that has pulled the line low must return it high for at least one clock before it lets go. A new owner must leave at least one idle clock after the previous owner lets go. The block watches the enables and data and raises one-cycle error pulses when these rules are broken. When two or more agents drive at once, the lowest-numbered enabled agent sets the resolved level.

Top module: `shared_line_resolver`

## Requirements
- R1: When no bit of `oe_i` is set, `line_o` is 1 in the same cycle.
- R2: When exactly one agent k has `oe_i[k]`=1, `line_o` equals `out_i[k]` in the same cycle.
- R3: When several enables are set, `line_o` equals `out_i` of the enabled agent with the smallest index.
- R4: `contention_o` is 1 for exactly the one cycle after each rising clock edge at which two or more bits of `oe_i` were sampled as 1. Otherwise it is 0.
- R5: `no_precharge_o` pulses for one cycle after an edge at which some agent's enable was sampled 0, provided that at the previous edge that agent's enable was 1 and its `out_i` was 0. A release after driving 1 gives no pulse.
- R6: `early_take_o` pulses for one cycle after an edge at which one agent's enable was sampled 0 (having been 1 at the previous edge) while another agent's enable was sampled 1 (having been 0 at the previous edge). A takeover after at least one cycle with that enable low and the old owner already released gives no pulse.
- R7: While `rst_ni` is low and right after it rises, all three error outputs are 0, the enable and data history is cleared, and `line_o` is 1 with no enables set.
- R8: The `out_i` bits of agents whose enable is 0 have no effect on `line_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; enables and data are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_i | input | N_AGENTS | Per-agent output enable |
| out_i | input | N_AGENTS | Per-agent driven value |
| line_o | output | 1 | Resolved line level seen by all agents |
| contention_o | output | 1 | One-cycle pulse: several agents drove at once |
| no_precharge_o | output | 1 | One-cycle pulse: an owner released after driving low |
| early_take_o | output | 1 | One-cycle pulse: takeover in the same cycle as a release |

## Verification
The resolved level has no state, so a fault in the priority path shows on `line_o` in the same cycle as the enable pattern that exposes it. The error flags depend on one registered copy of each agent's enable and data. A corrupted history bit either drops or invents a pulse exactly one clock after the offending edge, and clears after another clock. The bench therefore compares all four outputs on every cycle. It walks release-high, release-low, same-cycle takeover, gapped takeover and multi-driver patterns, so that each history bit is exercised in both of its values.

// File: rtl/slr_pkg.sv
package slr_pkg;
  localparam logic PULL_LEVEL = 1'b1;

  typedef struct packed {
    logic contention;
    logic no_precharge;
    logic early_take;
  } slr_err_t;
endpackage

// File: rtl/slr_prio_mux.sv
module slr_prio_mux
  import slr_pkg::*;
#(
  parameter int N_AGENTS = 4
) (
  input  logic [N_AGENTS-1:0] oe_i,
  input  logic [N_AGENTS-1:0] out_i,
  output logic                line_o
);
  // scan downward so the lowest enabled index is applied last and wins
  always_comb begin
    line_o = PULL_LEVEL;
    for (int i = N_AGENTS - 1; i >= 0; i--) begin
      if (oe_i[i]) line_o = out_i[i];
    end
  end
endmodule

// File: rtl/slr_handoff_chk.sv
module slr_handoff_chk
  import slr_pkg::*;
#(
  parameter int N_AGENTS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_AGENTS-1:0] oe_i,
  input  logic [N_AGENTS-1:0] out_i,
  output slr_err_t            err_o
);
  logic [N_AGENTS-1:0] prev_oe_q, prev_out_q;
  logic [N_AGENTS-1:0] fall_w, rise_w;
  logic                multi_w;
  slr_err_t            err_d, err_q;
  logic                past_ok_q;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_oe_q[g]  <= 1'b0;
        prev_out_q[g] <= 1'b0;
      end else begin
        prev_oe_q[g]  <= oe_i[g];
        prev_out_q[g] <= out_i[g];
      end
    end
    assign fall_w[g] = prev_oe_q[g] & ~oe_i[g];
    assign rise_w[g] = oe_i[g] & ~prev_oe_q[g];
  end

  // more than one bit set: clearing the lowest set bit leaves something
  assign multi_w = (oe_i & (oe_i - N_AGENTS'(1))) != '0;

  always_comb begin
    err_d.contention   = multi_w;
    err_d.no_precharge = |(fall_w & ~prev_out_q);
    err_d.early_take   = (|fall_w) & (|rise_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= '0;
      past_ok_q <= 1'b0;
    end else begin
      err_q     <= err_d;
      past_ok_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  a_r4_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(oe_i) > 1) |=> err_o.contention);

  a_r4_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(oe_i) <= 1) |=> !err_o.contention);

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_r5
    a_r5_low_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok_q && $fell(oe_i[g]) && !$past(out_i[g])) |=> err_o.no_precharge);
  end

  a_r6_early_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && (($past(oe_i) & ~oe_i) != '0) && ((oe_i & ~$past(oe_i)) != '0))
      |=> err_o.early_take);

  a_r7_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (err_o == '0));
endmodule

// File: rtl/shared_line_resolver.sv
module shared_line_resolver
  import slr_pkg::*;
#(
  parameter int N_AGENTS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_AGENTS-1:0] oe_i,
  input  logic [N_AGENTS-1:0] out_i,
  output logic                line_o,
  output logic                contention_o,
  output logic                no_precharge_o,
  output logic                early_take_o
);
  slr_err_t err_w;

  slr_prio_mux #(.N_AGENTS(N_AGENTS)) u_mux (
    .oe_i   (oe_i),
    .out_i  (out_i),
    .line_o (line_o)
  );

  slr_handoff_chk #(.N_AGENTS(N_AGENTS)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .oe_i   (oe_i),
    .out_i  (out_i),
    .err_o  (err_w)
  );

  assign contention_o   = err_w.contention;
  assign no_precharge_o = err_w.no_precharge;
  assign early_take_o   = err_w.early_take;

  a_r1_pullup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i == '0) |-> line_o);

  a_r2_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(oe_i) == 1) |-> (line_o == |(oe_i & out_i)));
endmodule

// File: tb/sim_shared_line_resolver.sv
module sim_shared_line_resolver;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] oe = '0, dout = '0;
  logic         line, cont, nopre, early;

  always #5 clk = ~clk;

  shared_line_resolver #(.N_AGENTS(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .oe_i(oe), .out_i(dout),
    .line_o(line), .contention_o(cont), .no_precharge_o(nopre), .early_take_o(early)
  );

  typedef struct {
    logic  line;
    logic  cont;
    logic  nopre;
    logic  early;
    string tag;
  } item_t;

  item_t        q[$];
  int           total = 0, bad = 0;
  logic [N-1:0] m_oe = '0, m_out = '0;
  bit           done = 0;

  task automatic chk(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] o, logic [N-1:0] d, string tag);
    item_t it;
    logic  f, r;
    @(negedge clk);
    it.line = 1'b1;
    for (int i = N - 1; i >= 0; i--) if (o[i]) it.line = d[i];
    it.cont  = $countones(o) > 1;
    it.nopre = |(m_oe & ~o & ~m_out);
    f = |(m_oe & ~o);
    r = |(o & ~m_oe);
    it.early = f & r;
    it.tag   = tag;
    q.push_back(it);
    oe = o; dout = d;
    m_oe = o; m_out = d;
  endtask

  // monitor: sample 2 ns after the edge that registered the pushed inputs
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, line, it.line, "line_o");
        chk("R4", cont, it.cont, "contention_o");
        chk("R5", nopre, it.nopre, "no_precharge_o");
        chk("R6", early, it.early, "early_take_o");
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R7", cont, 1'b0, "contention_o in reset");
    chk("R7", nopre, 1'b0, "no_precharge_o in reset");
    chk("R7", early, 1'b0, "early_take_o in reset");
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R7", line, 1'b1, "line_o after reset");
    chk("R7", cont | nopre | early, 1'b0, "flags after reset");

    step(4'b0000, 4'b0000, "R1");
    step(4'b0001, 4'b0000, "R2");
    step(4'b0001, 4'b0001, "R2");
    step(4'b0000, 4'b0000, "R1");   // release after high
    step(4'b0000, 4'b1111, "R8");
    step(4'b0010, 4'b0000, "R2");
    step(4'b0000, 4'b0000, "R1");   // release after low
    step(4'b0000, 4'b0000, "R1");
    step(4'b0100, 4'b0100, "R2");
    step(4'b1000, 4'b1000, "R2");   // same-cycle takeover
    step(4'b1000, 4'b0000, "R2");
    step(4'b0001, 4'b0001, "R2");   // takeover + low release
    step(4'b0000, 4'b0000, "R1");
    step(4'b0000, 4'b0000, "R1");
    step(4'b0100, 4'b0000, "R2");   // gapped takeover
    step(4'b0110, 4'b0100, "R3");
    step(4'b1010, 4'b0010, "R3");
    step(4'b1111, 4'b1110, "R3");
    step(4'b0100, 4'b1011, "R8");
    step(4'b0100, 4'b1111, "R8");
    step(4'b0100, 4'b0100, "R8");
    step(4'b0100, 4'b0100, "R8");
    step(4'b0000, 4'b0000, "R1");
    step(4'b0000, 4'b0000, "R1");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule